// File: doc/BRIEF.md
# Event Return Validation Unit

This unit serves the event controller of a processor core whenever a return-from-event command executes. The command names a return kind (emulation, non-maskable interrupt, exception or general interrupt). It arrives with the current pending-level vector and the saved return address that belongs to that kind. The unit works out which level is active and decides whether the return is allowed at that level. It then produces the next pending vector and the branch target.

A rejected return raises an illegal-resource exception request. A return that leaves no level active raises a user-mode transition pulse, which the core uses to swap its kernel and user stack-pointer aliases. Every accepted or rejected return ends with a pulse asking the arbiter to re-scan latched events. The unit does no arbitration of its own.

The pending vector uses fixed bit positions. Bit 0 is emulation, bit 1 is reset, bit 2 is the non-maskable interrupt, bit 3 is the exception level, and bit 4 is the global interrupt disable (not a level). Bits 5 to 15 are general interrupt levels. The active level is the lowest set bit among all bits except 0 and 4. With none set, the core is in user mode.

Top module: `evret_unit`

## Requirements
- R1: A command issued while no level is active (no pending bit set other than bits 0 and 4) sets `illegal_req` and changes nothing but bit 0.
- R2: `cmd_kind` encodes 0 = emulation, 1 = non-maskable, 2 = exception, 3 = general interrupt. A non-maskable return is legal only at active level 2, and an exception return only at active level 3. An emulation return is legal only at level 0; because bit 0 is cleared before the active level is found, an emulation return is always rejected.
- R3: A general interrupt return is rejected when the active level is 0, 2 or 3, or when no level is active. It is also rejected when the requested level is 4.
- R4: Bit 0 of the pending vector is cleared by every command that is not a range error, whether the command is legal or illegal.
- R5: On a legal return, the pending bit of the returned level is cleared when bit 0 of the saved address is 0. It is kept set when that bit is 1 (self-nesting tag).
- R6: On a legal return, `target` equals the saved address with bit 0 forced to 0. On an illegal return, `target` is 0.
- R7: On a legal return from level 1 or from any level of 5 or above, bit 4 is cleared. For levels 2 and 3, bit 4 is left as it was.
- R8: `to_user` pulses when a legal return leaves no bit set in `pend_out` other than bits 0 and 4.
- R9: Every command raises `done` for one cycle. Every command except a range error also raises `rescan` for one cycle.
- R10: A general interrupt return with `cmd_use_cur` = 0 and `cmd_level` of 16 or more raises `range_err`. In that case `pend_out` equals `pend_in`, `target` keeps its previous value, and no other pulse is raised.
- R11: Results appear on the outputs in the cycle after the command, and one command is accepted every cycle. Without a command, all pulses are low and `pend_out` and `target` hold their values.
- R12: For a general interrupt return with `cmd_use_cur` = 1, the returned level is the active level, and `cmd_level` is ignored (including any out-of-range value).
- R13: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A return command is present this cycle |
| cmd_kind | input | 2 | Return kind: 0 emulation, 1 non-maskable, 2 exception, 3 interrupt |
| cmd_use_cur | input | 1 | Interrupt return targets the active level |
| cmd_level | input | 5 | Requested level for an interrupt return |
| pend_in | input | 16 | Current pending-level vector |
| ret_addr | input | 32 | Saved return address for this kind |
| done | output | 1 | One-cycle pulse per command |
| pend_out | output | 16 | Next pending-level vector |
| target | output | 32 | Branch target |
| illegal_req | output | 1 | Illegal-resource exception request pulse |
| range_err | output | 1 | Requested level out of range pulse |
| to_user | output | 1 | Return to user mode pulse |
| rescan | output | 1 | Re-scan latched events pulse |

## Verification
Every result is due exactly one rising edge after the command is presented. The bench drives each command on a falling edge and checks all outputs on the next falling edge, half a period after the edge that registered them. Commands follow one another back to back, so each sample belongs to exactly one command. A final idle cycle shows that the pulses drop while `pend_out` and `target` hold their values.

// File: rtl/evr_pkg.sv
package evr_pkg;
  // Fixed pending-vector bit positions; the arbiter decodes the same layout.
  localparam int EMU_B  = 0;
  localparam int RST_B  = 1;
  localparam int NMI_B  = 2;
  localparam int EXC_B  = 3;
  localparam int GDIS_B = 4;
  localparam int GEN_B  = 5;

  typedef enum logic [1:0] {
    KIND_EMU = 2'd0,
    KIND_NMI = 2'd1,
    KIND_EXC = 2'd2,
    KIND_INT = 2'd3
  } ret_kind_e;
endpackage

// File: rtl/evr_level_find.sv
module evr_level_find #(
  parameter int N  = 16,
  parameter int LW = $clog2(N) + 1
) (
  input  logic [N-1:0]  vec,
  output logic          active,
  output logic [LW-1:0] lvl
);
  // Lowest set bit wins: scan downward so the last hit is the smallest index.
  always_comb begin
    active = 1'b0;
    lvl    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        active = 1'b1;
        lvl    = LW'(i);
      end
    end
  end
endmodule

// File: rtl/evr_legal.sv
module evr_legal #(
  parameter int LW = 5
) (
  input  evr_pkg::ret_kind_e kind,
  input  logic               active,
  input  logic [LW-1:0]      cur_lvl,
  input  logic [LW-1:0]      ret_lvl,
  output logic               legal
);
  import evr_pkg::*;

  logic at_emu, at_nmi, at_exc;

  assign at_emu = active && (cur_lvl == LW'(EMU_B));
  assign at_nmi = active && (cur_lvl == LW'(NMI_B));
  assign at_exc = active && (cur_lvl == LW'(EXC_B));

  always_comb begin
    unique case (kind)
      KIND_EMU: legal = at_emu;
      KIND_NMI: legal = at_nmi;
      KIND_EXC: legal = at_exc;
      default:  legal = active && !at_emu && !at_nmi && !at_exc
                        && (ret_lvl != LW'(GDIS_B));
    endcase
  end
endmodule

// File: rtl/evr_next.sv
module evr_next #(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int LW = $clog2(N) + 1
) (
  input  logic [N-1:0]  pend_clr,
  input  logic [LW-1:0] ret_lvl,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  pend_nx,
  output logic [AW-1:0] tgt_nx,
  output logic          user_nx
);
  import evr_pkg::*;

  localparam logic [N-1:0] NON_LVL = (N'(1) << EMU_B) | (N'(1) << GDIS_B);

  logic nest_tag;
  logic drop_gdis;

  assign nest_tag  = addr[0];
  assign drop_gdis = (ret_lvl >= LW'(GEN_B)) || (ret_lvl == LW'(RST_B));

  always_comb begin
    pend_nx = pend_clr;
    for (int i = 0; i < N; i++) begin
      if (!nest_tag && (ret_lvl == LW'(i))) pend_nx[i] = 1'b0;
    end
    if (drop_gdis) pend_nx[GDIS_B] = 1'b0;
  end

  assign tgt_nx  = {addr[AW-1:1], 1'b0};
  assign user_nx = ((pend_nx & ~NON_LVL) == '0);
endmodule

// File: rtl/evret_unit.sv
module evret_unit #(
  parameter int N  = 16,
  parameter int AW = 32,
  parameter int LW = $clog2(N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_kind,
  input  logic          cmd_use_cur,
  input  logic [LW-1:0] cmd_level,
  input  logic [N-1:0]  pend_in,
  input  logic [AW-1:0] ret_addr,
  output logic          done,
  output logic [N-1:0]  pend_out,
  output logic [AW-1:0] target,
  output logic          illegal_req,
  output logic          range_err,
  output logic          to_user,
  output logic          rescan
);
  import evr_pkg::*;

  localparam logic [N-1:0] EMU_M  = N'(1) << EMU_B;
  localparam logic [N-1:0] GDIS_M = N'(1) << GDIS_B;

  ret_kind_e     kind;
  logic [N-1:0]  pend_clr, lvl_vec, pend_nx;
  logic          active, legal, lvl_bad, user_nx;
  logic [LW-1:0] cur_lvl, ret_lvl;
  logic [AW-1:0] tgt_nx;

  // next-state signals
  logic          done_d, ill_d, rng_d, usr_d, scan_d;
  logic [N-1:0]  pend_d;
  logic [AW-1:0] tgt_d;

  assign kind     = ret_kind_e'(cmd_kind);
  assign pend_clr = pend_in & ~EMU_M;
  assign lvl_vec  = pend_clr & ~GDIS_M;
  assign lvl_bad  = (kind == KIND_INT) && !cmd_use_cur && (cmd_level >= LW'(N));

  evr_level_find #(.N(N), .LW(LW)) u_find (
    .vec    (lvl_vec),
    .active (active),
    .lvl    (cur_lvl)
  );

  always_comb begin
    unique case (kind)
      KIND_EMU: ret_lvl = LW'(EMU_B);
      KIND_NMI: ret_lvl = LW'(NMI_B);
      KIND_EXC: ret_lvl = LW'(EXC_B);
      default:  ret_lvl = cmd_use_cur ? cur_lvl : cmd_level;
    endcase
  end

  evr_legal #(.LW(LW)) u_legal (
    .kind    (kind),
    .active  (active),
    .cur_lvl (cur_lvl),
    .ret_lvl (ret_lvl),
    .legal   (legal)
  );

  evr_next #(.N(N), .AW(AW), .LW(LW)) u_next (
    .pend_clr (pend_clr),
    .ret_lvl  (ret_lvl),
    .addr     (ret_addr),
    .pend_nx  (pend_nx),
    .tgt_nx   (tgt_nx),
    .user_nx  (user_nx)
  );

  always_comb begin
    done_d = 1'b0;
    ill_d  = 1'b0;
    rng_d  = 1'b0;
    usr_d  = 1'b0;
    scan_d = 1'b0;
    pend_d = pend_out;
    tgt_d  = target;
    if (cmd_valid) begin
      done_d = 1'b1;
      if (lvl_bad) begin
        rng_d  = 1'b1;
        pend_d = pend_in;
      end else begin
        scan_d = 1'b1;
        if (legal) begin
          pend_d = pend_nx;
          tgt_d  = tgt_nx;
          usr_d  = user_nx;
        end else begin
          ill_d  = 1'b1;
          pend_d = pend_clr;
          tgt_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      illegal_req <= 1'b0;
      range_err   <= 1'b0;
      to_user     <= 1'b0;
      rescan      <= 1'b0;
      pend_out    <= '0;
      target      <= '0;
    end else begin
      done        <= done_d;
      illegal_req <= ill_d;
      range_err   <= rng_d;
      to_user     <= usr_d;
      rescan      <= scan_d;
      if (cmd_valid) begin
        pend_out <= pend_d;
        target   <= tgt_d;
      end
    end
  end
endmodule

// File: rtl/evret_unit_chk.sv
module evret_unit_chk #(
  parameter int N  = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_kind,
  input logic [N-1:0]  pend_in,
  input logic          done,
  input logic [N-1:0]  pend_out,
  input logic [AW-1:0] target,
  input logic          illegal_req,
  input logic          range_err,
  input logic          to_user,
  input logic          rescan
);
  localparam logic [N-1:0] NON_LVL = N'(17);

  AST_USER_RET_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && ((pend_in & ~NON_LVL) == '0) |=> illegal_req || range_err); // R1

  AST_NMI_ONLY_AT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd1 && !(pend_in[2] && !pend_in[1]) |=> illegal_req); // R2

  AST_EXC_ONLY_AT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd2 && !(pend_in[3] && pend_in[2:1] == 2'b00) |=> illegal_req); // R2

  AST_EMU_RET_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd0 |=> illegal_req); // R2

  AST_EMU_BIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    done && !range_err |-> !pend_out[0]); // R4

  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    done && !range_err |-> !target[0]); // R6

  AST_USER_MATCHES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal_req && !range_err |-> to_user == ((pend_out & ~NON_LVL) == '0)); // R8

  AST_DONE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done); // R9

  AST_RESCAN_UNLESS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rescan == !range_err); // R9

  AST_RANGE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !range_err || (pend_out == $past(pend_in) && !illegal_req && !to_user)); // R10

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done && !rescan && !illegal_req && $stable(pend_out) && $stable(target)); // R11
endmodule

bind evret_unit evret_unit_chk #(.N(N), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_kind    (cmd_kind),
  .pend_in     (pend_in),
  .done        (done),
  .pend_out    (pend_out),
  .target      (target),
  .illegal_req (illegal_req),
  .range_err   (range_err),
  .to_user     (to_user),
  .rescan      (rescan)
);

// File: tb/tb_evret_unit.sv
`timescale 1ns/1ps
module tb_evret_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic        cmd_use_cur = 1'b0;
  logic [4:0]  cmd_level = 5'd0;
  logic [15:0] pend_in = 16'h0;
  logic [31:0] ret_addr = 32'h0;
  logic        done, illegal_req, range_err, to_user, rescan;
  logic [15:0] pend_out;
  logic [31:0] target;

  int checks = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  evret_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_use_cur(cmd_use_cur), .cmd_level(cmd_level), .pend_in(pend_in),
    .ret_addr(ret_addr), .done(done), .pend_out(pend_out), .target(target),
    .illegal_req(illegal_req), .range_err(range_err), .to_user(to_user),
    .rescan(rescan)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        uc;
    logic [4:0]  lvl;
    logic [15:0] pend;
    logic [31:0] addr;
    logic [15:0] xp;
    logic [31:0] xt;
    logic        xi;
    logic        xr;
    logic        xu;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 5'd11, 16'h0810, 32'h1000, 16'h0000, 32'h1000, 1'b0, 1'b0, 1'b1}, // R7 R8
    '{2'd3, 1'b0, 5'd11, 16'h0850, 32'h2000, 16'h0040, 32'h2000, 1'b0, 1'b0, 1'b0}, // R5
    '{2'd3, 1'b1, 5'd0,  16'h8000, 32'h3001, 16'h8000, 32'h3000, 1'b0, 1'b0, 1'b0}, // R5 R12
    '{2'd1, 1'b0, 5'd0,  16'h0014, 32'h0044, 16'h0010, 32'h0044, 1'b0, 1'b0, 1'b1}, // R2 R7
    '{2'd2, 1'b0, 5'd0,  16'h0108, 32'h0050, 16'h0100, 32'h0050, 1'b0, 1'b0, 1'b0}, // R2
    '{2'd3, 1'b0, 5'd20, 16'h0080, 32'h0000, 16'h0080, 32'h0050, 1'b0, 1'b1, 1'b0}, // R10
    '{2'd2, 1'b0, 5'd0,  16'h0104, 32'h0058, 16'h0104, 32'h0000, 1'b1, 1'b0, 1'b0}, // R2
    '{2'd0, 1'b0, 5'd0,  16'h0009, 32'h0060, 16'h0008, 32'h0000, 1'b1, 1'b0, 1'b0}, // R2 R4
    '{2'd3, 1'b0, 5'd7,  16'h0000, 32'h0070, 16'h0000, 32'h0000, 1'b1, 1'b0, 1'b0}, // R1
    '{2'd3, 1'b0, 5'd1,  16'h0012, 32'h0080, 16'h0000, 32'h0080, 1'b0, 1'b0, 1'b1}, // R7
    '{2'd3, 1'b0, 5'd5,  16'h0024, 32'h0084, 16'h0024, 32'h0000, 1'b1, 1'b0, 1'b0}, // R3
    '{2'd3, 1'b0, 5'd4,  16'h0030, 32'h0088, 16'h0030, 32'h0000, 1'b1, 1'b0, 1'b0}, // R3
    '{2'd1, 1'b0, 5'd0,  16'h0005, 32'h0091, 16'h0004, 32'h0090, 1'b0, 1'b0, 1'b0}, // R4 R5 R6
    '{2'd3, 1'b1, 5'd25, 16'h0240, 32'h00A0, 16'h0200, 32'h00A0, 1'b0, 1'b0, 1'b0}  // R12
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cmd_valid   = 1'b1;
    cmd_kind    = v.kind;
    cmd_use_cur = v.uc;
    cmd_level   = v.lvl;
    pend_in     = v.pend;
    ret_addr    = v.addr;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13: outputs cleared by reset
    chk("R13 reset done", 32'(done), 32'd0);
    chk("R13 reset pend_out", 32'(pend_out), 32'd0);
    chk("R13 reset target", target, 32'd0);
    chk("R13 reset pulses", 32'({illegal_req, range_err, to_user, rescan}), 32'd0);
    rst_n = 1'b1;

    @(negedge clk);
    drive(VECS[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      // R11: every result checked one edge after its command, back to back
      chk($sformatf("R11 R9 vec%0d done", i), 32'(done), 32'd1);
      chk($sformatf("R4 R5 R7 vec%0d pend_out", i), 32'(pend_out), 32'(VECS[i].xp));
      chk($sformatf("R6 vec%0d target", i), target, VECS[i].xt);
      chk($sformatf("R1 R2 R3 vec%0d illegal_req", i), 32'(illegal_req), 32'(VECS[i].xi));
      chk($sformatf("R10 vec%0d range_err", i), 32'(range_err), 32'(VECS[i].xr));
      chk($sformatf("R8 vec%0d to_user", i), 32'(to_user), 32'(VECS[i].xu));
      chk($sformatf("R9 vec%0d rescan", i), 32'(rescan), 32'(!VECS[i].xr));
      if (i + 1 < NV) drive(VECS[i + 1]);
      else cmd_valid = 1'b0;
    end

    // R11: idle cycle drops pulses and holds pending vector and target
    pend_in  = 16'hFFFF;
    ret_addr = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R11 idle pulses", 32'({done, illegal_req, range_err, to_user, rescan}), 32'd0);
    chk("R11 idle pend_out hold", 32'(pend_out), 32'h0200);
    chk("R11 idle target hold", target, 32'h00A0);

    // R13: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    chk("R13 mid reset pend_out", 32'(pend_out), 32'd0);
    chk("R13 mid reset target", target, 32'd0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule